// File: doc/BRIEF.md
# SPI Flash Access Protection Unit

This unit sits between the host's register interface and the SPI flash command engine. It decides whether each command that software programs into the engine may start. Every command arrives with a kind (read, write, erase or direct read) and a 25-bit flash byte address. Before the engine issues any serial cycle, the unit returns a registered verdict: allow or block.

Two mechanisms decide the verdict. The first is a set of five address windows. Each window can refuse reads, writes and erases that fall inside it. The windows can be frozen until reset. The second is a global write guard. While the guard is closed, every write and erase is refused. Once a lock-enable bit is set, only code running in the privileged mode can open the guard. An unprivileged attempt to open it can raise a one-cycle interrupt request.

Direct reads from the memory-mapped path are marked by their own command kind. They always pass. A blocked command sets a sticky violation flag that software clears by writing a one to it.

Top module: `flashProtUnit`

## Requirements
- R1: A read (kind 0) is blocked when its page, address bits [24:12], satisfies base <= page <= limit for any window whose read-protect bit is 1. A window with limit < base matches no page. Window register k (k = 0..4) holds the base in bits [12:0], the limit in [25:13], read-protect in bit 26 and write-protect in bit 27.
- R2: A direct read (kind 3) is always allowed, whatever the windows and the guard hold, and it never sets the violation flag.
- R3: Bit 8 of the control register (address 5) is the window freeze. Writing 1 sets it, and writing 0 does not clear it. While it is 1, writes to window registers 0..4 are ignored. Only reset clears it.
- R4: While the guard-open bit (control bit 0) is 0, every write (kind 1) and erase (kind 2) is blocked.
- R5: While the guard-open bit is 1, a write or erase is blocked only when its page lies in a window whose write-protect bit is 1.
- R6: Control bit 1 (lock-enable) is set-only and clears only on reset. When lock-enable is 1 before a control write, writing 1 to bit 0 opens the guard only if privMode is 1 in that cycle; otherwise bit 0 keeps its old value. Writing 0 to bit 0 always closes the guard.
- R7: Control bit 2 (interrupt-enable) is a plain read/write bit. When it is 1 before a control write that has bit 0 = 1 and privMode = 0, wpIrq is 1 for exactly the next cycle.
- R8: A blocked verdict drives decError and sets the violation flag (status register, address 6, bit 0). Writing 1 to that bit clears the flag. If a block and a clear fall in the same cycle, the flag stays set.
- R9: A command is accepted when cmdValid is 1 and either no verdict is held or cmdAck is 1 in the same cycle. Its verdict appears on decValid/decAllow one clock later and is held unchanged until cmdAck. A cmdValid while a verdict is held without cmdAck is ignored.
- R10: After reset all registers read 0, decValid is 0 and wpIrq is 0. Register addresses 0..4 are the windows, 5 is control, 6 is status and 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 3 | Register write address |
| regWrData | input | 32 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 32 | Register read data (combinational) |
| privMode | input | 1 | Host is running in privileged mode |
| cmdValid | input | 1 | Command presented for a verdict |
| cmdKind | input | 2 | 0 read, 1 write, 2 erase, 3 direct read |
| cmdAddr | input | 25 | Command flash byte address |
| cmdAck | input | 1 | Command engine consumed the verdict |
| decValid | output | 1 | Verdict held |
| decAllow | output | 1 | Verdict: command may start |
| decError | output | 1 | Verdict: command blocked |
| violation | output | 1 | Sticky blocked-command flag |
| wpIrq | output | 1 | Interrupt request pulse |

## Verification
A wrong stored window field, freeze bit or guard bit never shows up alone. It shows as a wrong verdict on the first command that touches the affected page or kind, one clock after that command is accepted. It also shows at once on regRdData when that register is selected. A broken hold or acceptance path shows as decAllow changing, or decValid dropping, while a verdict waits for cmdAck. A wrong lock-enable or interrupt-enable bit shows one cycle after the next control write: as a missing or spurious wpIrq pulse, or as a guard bit that opens without privilege. The bench compares every output with a behavioural model on every cycle, so any such divergence is reported within one cycle of becoming visible.

// File: rtl/flash_prot_pkg.sv
`timescale 1ns/1ps
package flash_prot_pkg;
  localparam int NUM_RANGES  = 5;
  localparam int PAGE_W      = 13;
  localparam int PAGE_SHIFT  = 12;
  localparam int ADDR_W      = PAGE_W + PAGE_SHIFT;
  localparam int REG_W       = 32;
  localparam int REG_AW      = 3;

  localparam logic [REG_AW-1:0] CTRL_ADDR   = REG_AW'(NUM_RANGES);
  localparam logic [REG_AW-1:0] STATUS_ADDR = REG_AW'(NUM_RANGES + 1);

  // window register field positions
  localparam int BASE_LSB  = 0;
  localparam int LIMIT_LSB = PAGE_W;
  localparam int RDEN_BIT  = 2 * PAGE_W;
  localparam int WREN_BIT  = 2 * PAGE_W + 1;

  // control register bit positions
  localparam int WPOFF_BIT  = 0;
  localparam int LOCKEN_BIT = 1;
  localparam int IRQEN_BIT  = 2;
  localparam int RLOCK_BIT  = 8;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_ERASE  = 2'd2,
    CMD_DIRECT = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic [NUM_RANGES-1:0] rangeLoad;
    logic                  capture;
    logic                  writesOpen;
  } ctrl_strobe_t;
endpackage

// File: rtl/fpuRangeMatch.sv
`timescale 1ns/1ps
module fpuRangeMatch #(
  parameter int PageW = 13
) (
  input  logic [PageW-1:0] base,
  input  logic [PageW-1:0] limit,
  input  logic [PageW-1:0] page,
  input  logic             rdEn,
  input  logic             wrEn,
  output logic             rdHit,
  output logic             wrHit
);
  logic inWindow;

  // an inverted window (limit < base) can never satisfy both sides
  always_comb begin
    inWindow = (page >= base) && (page <= limit);
    rdHit    = inWindow && rdEn;
    wrHit    = inWindow && wrEn;
  end
endmodule

// File: rtl/fpuDatapath.sv
`timescale 1ns/1ps
module fpuDatapath
  import flash_prot_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobe_t        strobes,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [1:0]          cmdKind,
  input  logic [ADDR_W-1:0]   cmdAddr,
  input  logic [REG_AW-1:0]   regRdAddr,
  output logic                blockNext,
  output logic                decAllow,
  output logic [REG_W-1:0]    rangeRdData
);
  logic [PAGE_W-1:0]     baseQ  [NUM_RANGES];
  logic [PAGE_W-1:0]     limitQ [NUM_RANGES];
  logic [NUM_RANGES-1:0] rdEnQ;
  logic [NUM_RANGES-1:0] wrEnQ;
  logic [NUM_RANGES-1:0] rdHit;
  logic [NUM_RANGES-1:0] wrHit;
  logic [PAGE_W-1:0]     page;
  logic                  isRead;
  logic                  isModify;
  logic                  unusedDpBits;

  assign page         = cmdAddr[ADDR_W-1:PAGE_SHIFT];
  assign unusedDpBits = ^{cmdAddr[PAGE_SHIFT-1:0], regWrData[REG_W-1:WREN_BIT+1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        baseQ[i]  <= '0;
        limitQ[i] <= '0;
      end
      rdEnQ <= '0;
      wrEnQ <= '0;
    end else begin
      for (int i = 0; i < NUM_RANGES; i++) begin
        if (strobes.rangeLoad[i]) begin
          baseQ[i]  <= regWrData[BASE_LSB +: PAGE_W];
          limitQ[i] <= regWrData[LIMIT_LSB +: PAGE_W];
          rdEnQ[i]  <= regWrData[RDEN_BIT];
          wrEnQ[i]  <= regWrData[WREN_BIT];
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_RANGES; g++) begin : genWindow
      fpuRangeMatch #(.PageW(PAGE_W)) uMatch (
        .base  (baseQ[g]),
        .limit (limitQ[g]),
        .page  (page),
        .rdEn  (rdEnQ[g]),
        .wrEn  (wrEnQ[g]),
        .rdHit (rdHit[g]),
        .wrHit (wrHit[g])
      );
    end
  endgenerate

  always_comb begin
    isRead    = (cmdKind == CMD_READ);
    isModify  = (cmdKind == CMD_WRITE) || (cmdKind == CMD_ERASE);
    blockNext = 1'b0;
    if (isRead)   blockNext = |rdHit;
    if (isModify) blockNext = !strobes.writesOpen || (|wrHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                decAllow <= 1'b0;
    else if (strobes.capture) decAllow <= !blockNext;
  end

  always_comb begin
    rangeRdData = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (regRdAddr == REG_AW'(i)) begin
        rangeRdData[BASE_LSB +: PAGE_W]  = baseQ[i];
        rangeRdData[LIMIT_LSB +: PAGE_W] = limitQ[i];
        rangeRdData[RDEN_BIT]            = rdEnQ[i];
        rangeRdData[WREN_BIT]            = wrEnQ[i];
      end
    end
  end

  // R2: direct reads pass regardless of windows or guard
  assert_direct_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && cmdKind == CMD_DIRECT) |=> decAllow);

  // R4: closed guard refuses every write and erase
  assert_guard_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.writesOpen &&
     (cmdKind == CMD_WRITE || cmdKind == CMD_ERASE)) |=> !decAllow);
endmodule

// File: rtl/fpuCtrl.sv
`timescale 1ns/1ps
module fpuCtrl
  import flash_prot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regWrAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               privMode,
  input  logic               cmdValid,
  input  logic               cmdAck,
  input  logic               blockNext,
  output ctrl_strobe_t       strobes,
  output logic               decValid,
  output logic               violation,
  output logic               wpIrq,
  output logic [REG_W-1:0]   ctrlWord,
  output logic [REG_W-1:0]   statusWord
);
  logic wpOff;
  logic lockEn;
  logic irqEn;
  logic rangeLock;
  logic ctrlWr;
  logic statWr;
  logic trySet;
  logic setDenied;
  logic canAccept;
  logic unusedCtrlBits;

  assign unusedCtrlBits = ^{regWrData[REG_W-1:RLOCK_BIT+1], regWrData[RLOCK_BIT-1:IRQEN_BIT+1]};

  always_comb begin
    ctrlWr     = regWrEn && (regWrAddr == CTRL_ADDR);
    statWr     = regWrEn && (regWrAddr == STATUS_ADDR);
    trySet     = ctrlWr && regWrData[WPOFF_BIT];
    setDenied  = trySet && lockEn && !privMode;
    canAccept  = !decValid || cmdAck;
    strobes.capture    = cmdValid && canAccept;
    strobes.writesOpen = wpOff;
    for (int i = 0; i < NUM_RANGES; i++) begin
      strobes.rangeLoad[i] = regWrEn && !rangeLock && (regWrAddr == REG_AW'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpOff     <= 1'b0;
      lockEn    <= 1'b0;
      irqEn     <= 1'b0;
      rangeLock <= 1'b0;
      wpIrq     <= 1'b0;
      decValid  <= 1'b0;
      violation <= 1'b0;
    end else begin
      if (ctrlWr) begin
        if (!regWrData[WPOFF_BIT]) wpOff <= 1'b0;
        else if (!setDenied)       wpOff <= 1'b1;
        lockEn    <= lockEn | regWrData[LOCKEN_BIT];
        irqEn     <= regWrData[IRQEN_BIT];
        rangeLock <= rangeLock | regWrData[RLOCK_BIT];
      end
      wpIrq <= trySet && irqEn && !privMode;
      if (strobes.capture) decValid <= 1'b1;
      else if (cmdAck)     decValid <= 1'b0;
      if (strobes.capture && blockNext)     violation <= 1'b1;
      else if (statWr && regWrData[0])      violation <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord             = '0;
    ctrlWord[WPOFF_BIT]  = wpOff;
    ctrlWord[LOCKEN_BIT] = lockEn;
    ctrlWord[IRQEN_BIT]  = irqEn;
    ctrlWord[RLOCK_BIT]  = rangeLock;
    statusWord           = '0;
    statusWord[0]        = violation;
  end

  // R3: window freeze is never released before reset
  assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(rangeLock));

  // R6: lock-enable is set-only
  assert_lock_setonly_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(lockEn));

  // R6: with lock-enable on, the guard opens only under privilege
  assert_priv_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wpOff) && $past(lockEn)) |-> $past(privMode));

  // R7: an interrupt pulse needs interrupt-enable and an unprivileged writer
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    wpIrq |-> ($past(irqEn) && !$past(privMode)));
endmodule

// File: rtl/flashProtUnit.sv
`timescale 1ns/1ps
module flashProtUnit
  import flash_prot_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regWrAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic [REG_AW-1:0]  regRdAddr,
  output logic [REG_W-1:0]   regRdData,
  input  logic               privMode,
  input  logic               cmdValid,
  input  logic [1:0]         cmdKind,
  input  logic [ADDR_W-1:0]  cmdAddr,
  input  logic               cmdAck,
  output logic               decValid,
  output logic               decAllow,
  output logic               decError,
  output logic               violation,
  output logic               wpIrq
);
  ctrl_strobe_t      strobes;
  logic              blockNext;
  logic [REG_W-1:0]  ctrlWord;
  logic [REG_W-1:0]  statusWord;
  logic [REG_W-1:0]  rangeRdData;

  fpuCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .privMode   (privMode),
    .cmdValid   (cmdValid),
    .cmdAck     (cmdAck),
    .blockNext  (blockNext),
    .strobes    (strobes),
    .decValid   (decValid),
    .violation  (violation),
    .wpIrq      (wpIrq),
    .ctrlWord   (ctrlWord),
    .statusWord (statusWord)
  );

  fpuDatapath uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .regWrData   (regWrData),
    .cmdKind     (cmdKind),
    .cmdAddr     (cmdAddr),
    .regRdAddr   (regRdAddr),
    .blockNext   (blockNext),
    .decAllow    (decAllow),
    .rangeRdData (rangeRdData)
  );

  always_comb begin
    if (regRdAddr == CTRL_ADDR)        regRdData = ctrlWord;
    else if (regRdAddr == STATUS_ADDR) regRdData = statusWord;
    else                               regRdData = rangeRdData;
  end

  assign decError = decValid && !decAllow;

  // R9: a held verdict stays valid and unchanged until acknowledged
  assert_verdict_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && !cmdAck) |=> (decValid && $stable(decAllow)));

  // R8: a blocked verdict always leaves the violation flag set on arrival
  assert_block_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(decValid) && !decAllow) |-> violation);
endmodule

// File: tb/tb_flashProtUnit.sv
`timescale 1ns/1ps
module tb_flashProtUnit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [2:0]  regWrAddr;
  logic [31:0] regWrData;
  logic [2:0]  regRdAddr;
  logic [31:0] regRdData;
  logic        privMode;
  logic        cmdValid;
  logic [1:0]  cmdKind;
  logic [24:0] cmdAddr;
  logic        cmdAck;
  logic        decValid, decAllow, decError, violation, wpIrq;

  int    checks = 0;
  int    fails  = 0;
  string curReq = "R10";
  bit    done   = 0;

  always #10 clk = ~clk;

  flashProtUnit dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .privMode(privMode), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdAddr(cmdAddr), .cmdAck(cmdAck), .decValid(decValid),
    .decAllow(decAllow), .decError(decError), .violation(violation),
    .wpIrq(wpIrq)
  );

  // ---------------- behavioural reference model ----------------
  int mBase[5], mLimit[5];
  bit mRd[5], mWr[5];
  bit mWpOff, mLockEn, mIrqEn, mRLock, mSticky, mDecValid, mDecAllow, mIrq;

  task automatic modelReset();
    for (int i = 0; i < 5; i++) begin
      mBase[i] = 0; mLimit[i] = 0; mRd[i] = 0; mWr[i] = 0;
    end
    mWpOff = 0; mLockEn = 0; mIrqEn = 0; mRLock = 0;
    mSticky = 0; mDecValid = 0; mDecAllow = 0; mIrq = 0;
  endtask

  function automatic bit mBlock(int kind, int addr);
    int  pg = (addr >> 12) & 'h1FFF;
    bit  rdHit = 0, wrHit = 0;
    for (int i = 0; i < 5; i++) begin
      if (pg >= mBase[i] && pg <= mLimit[i]) begin
        if (mRd[i]) rdHit = 1;
        if (mWr[i]) wrHit = 1;
      end
    end
    if (kind == 0) return rdHit;
    if (kind == 3) return 0;
    return !mWpOff || wrHit;
  endfunction

  function automatic logic [31:0] mRead(int a);
    logic [31:0] v = 0;
    if (a < 5) v = (32'(mWr[a]) << 27) | (32'(mRd[a]) << 26) |
                   (32'(mLimit[a]) << 13) | 32'(mBase[a]);
    else if (a == 5) v = (32'(mRLock) << 8) | (32'(mIrqEn) << 2) |
                         (32'(mLockEn) << 1) | 32'(mWpOff);
    else if (a == 6) v = 32'(mSticky);
    return v;
  endfunction

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit cap, blk, nIrq, oldLock;
      cap     = cmdValid && (!mDecValid || cmdAck);
      blk     = mBlock(int'(cmdKind), int'(cmdAddr));
      nIrq    = regWrEn && regWrAddr == 5 && regWrData[0] && !privMode && mIrqEn;
      oldLock = mLockEn;
      if (cap) begin mDecValid = 1; mDecAllow = !blk; end
      else if (cmdAck) mDecValid = 0;
      if (cap && blk) mSticky = 1;
      else if (regWrEn && regWrAddr == 6 && regWrData[0]) mSticky = 0;
      if (regWrEn) begin
        if (regWrAddr < 5 && !mRLock) begin
          mBase[regWrAddr]  = int'(regWrData[12:0]);
          mLimit[regWrAddr] = int'(regWrData[25:13]);
          mRd[regWrAddr]    = regWrData[26];
          mWr[regWrAddr]    = regWrData[27];
        end else if (regWrAddr == 5) begin
          if (!regWrData[0]) mWpOff = 0;
          else if (!(oldLock && !privMode)) mWpOff = 1;
          mLockEn = mLockEn | regWrData[1];
          mIrqEn  = regWrData[2];
          mRLock  = mRLock | regWrData[8];
        end
      end
      mIrq = nIrq;
    end
  end

  // ---------------- checking ----------------
  task automatic check(logic [31:0] act, logic [31:0] exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN === 1'b1 && !done) begin
      check(32'(decValid),  32'(mDecValid), curReq, "decValid");
      if (mDecValid) begin
        check(32'(decAllow), 32'(mDecAllow),  curReq, "decAllow");
        check(32'(decError), 32'(!mDecAllow), curReq, "decError");
      end
      check(32'(violation), 32'(mSticky), curReq, "violation");
      check(32'(wpIrq),     32'(mIrq),    curReq, "wpIrq");
      check(regRdData, mRead(int'(regRdAddr)), curReq, "regRdData");
    end
  end

  task automatic tick(); @(posedge clk); #5; endtask

  task automatic wrReg(int a, logic [31:0] d, bit priv);
    regWrEn = 1; regWrAddr = 3'(a); regWrData = d; privMode = priv;
    tick();
    regWrEn = 0; privMode = 0;
  endtask

  task automatic rdExpect(int a, logic [31:0] exp, string req);
    regRdAddr = 3'(a);
    #1;
    check(regRdData, exp, req, "readback");
  endtask

  task automatic issueExpect(int kind, int addr, bit expAllow, string req);
    cmdValid = 1; cmdKind = 2'(kind); cmdAddr = 25'(addr); cmdAck = 0;
    tick();
    cmdValid = 0;
    check(32'(decValid), 1, req, "decValid");
    check(32'(decAllow), 32'(expAllow), req, "decAllow");
    check(32'(decError), 32'(!expAllow), req, "decError");
    cmdAck = 1;
    tick();
    cmdAck = 0;
  endtask

  function automatic logic [31:0] mkRange(int b, int l, bit rd, bit wr);
    return (32'(wr) << 27) | (32'(rd) << 26) | (32'(l) << 13) | 32'(b);
  endfunction

  task automatic finishRun();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 0; regWrEn = 0; regWrAddr = 0; regWrData = 0; regRdAddr = 0;
    privMode = 0; cmdValid = 0; cmdKind = 0; cmdAddr = 0; cmdAck = 0;
    repeat (3) tick();
    rstN = 1;
    tick();

    // R10: reset state
    curReq = "R10";
    for (int a = 0; a < 8; a++) rdExpect(a, 0, "R10");
    check(32'(decValid), 0, "R10", "decValid after reset");
    check(32'(wpIrq), 0, "R10", "wpIrq after reset");

    // R4: guard closed blocks writes and erases, not reads
    curReq = "R4";
    issueExpect(1, 'h300000, 0, "R4");
    issueExpect(2, 'h300000, 0, "R4");
    issueExpect(0, 'h300000, 1, "R4");

    // R8: sticky flag and write-one clear
    curReq = "R8";
    check(32'(violation), 1, "R8", "violation set");
    wrReg(6, 1, 0);
    check(32'(violation), 0, "R8", "violation cleared");

    // R1: window reads
    curReq = "R1";
    wrReg(0, mkRange('h010, 'h01F, 1, 1), 0);
    wrReg(1, mkRange('h100, 'h0FF, 1, 1), 0);
    wrReg(2, mkRange('h200, 'h200, 0, 1), 0);
    rdExpect(0, mkRange('h010, 'h01F, 1, 1), "R10");
    issueExpect(0, 'h010000, 0, "R1");
    issueExpect(0, 'h01FFFF, 0, "R1");
    issueExpect(0, 'h020000, 1, "R1");
    issueExpect(0, 'h00FFFF, 1, "R1");
    issueExpect(0, 'h100000, 1, "R1");
    issueExpect(0, 'h200000, 1, "R1");

    // R2: direct reads pass and leave the flag alone
    curReq = "R2";
    wrReg(6, 1, 0);
    issueExpect(3, 'h015000, 1, "R2");
    check(32'(violation), 0, "R2", "violation after direct read");

    // R5: guard open, only write-protected windows refuse
    curReq = "R5";
    wrReg(5, 1, 0);
    rdExpect(5, 1, "R5");
    issueExpect(1, 'h300000, 1, "R5");
    issueExpect(2, 'h200000, 0, "R5");
    issueExpect(1, 'h201000, 1, "R5");
    issueExpect(1, 'h100000, 1, "R5");
    issueExpect(2, 'h018000, 0, "R5");

    // R8: set wins over a same-cycle clear
    curReq = "R8";
    regWrEn = 1; regWrAddr = 6; regWrData = 1;
    cmdValid = 1; cmdKind = 1; cmdAddr = 'h018000;
    tick();
    regWrEn = 0; cmdValid = 0;
    check(32'(violation), 1, "R8", "set wins over clear");
    cmdAck = 1; tick(); cmdAck = 0;
    wrReg(6, 1, 0);
    check(32'(violation), 0, "R8", "violation cleared");

    // R6: lock-enable and privileged opening
    curReq = "R6";
    wrReg(5, 'h2, 0);
    rdExpect(5, 'h2, "R6");
    wrReg(5, 'h3, 0);
    rdExpect(5, 'h2, "R6");
    issueExpect(1, 'h300000, 0, "R6");
    wrReg(5, 'h3, 1);
    rdExpect(5, 'h3, "R6");
    issueExpect(1, 'h300000, 1, "R6");
    wrReg(5, 'h0, 0);
    rdExpect(5, 'h2, "R6");

    // R7: interrupt pulse on unprivileged opening attempt
    curReq = "R7";
    wrReg(5, 'h6, 0);
    check(32'(wpIrq), 0, "R7", "no pulse without attempt");
    wrReg(5, 'h7, 0);
    check(32'(wpIrq), 1, "R7", "pulse on attempt");
    tick();
    check(32'(wpIrq), 0, "R7", "pulse lasts one cycle");
    wrReg(5, 'h7, 1);
    check(32'(wpIrq), 0, "R7", "no pulse when privileged");
    rdExpect(5, 'h7, "R7");

    // R9: hold until acknowledge, ignore unacknowledged requests
    curReq = "R9";
    cmdValid = 1; cmdKind = 0; cmdAddr = 'h010000;
    tick();
    cmdValid = 0;
    for (int k = 0; k < 3; k++) begin
      check(32'(decValid), 1, "R9", "held valid");
      check(32'(decAllow), 0, "R9", "held verdict");
      tick();
    end
    cmdAck = 1; cmdValid = 1; cmdKind = 3;
    tick();
    cmdAck = 0; cmdValid = 0;
    check(32'(decAllow), 1, "R9", "back-to-back verdict");
    cmdValid = 1; cmdKind = 0; cmdAddr = 'h010000;
    tick();
    cmdValid = 0;
    check(32'(decAllow), 1, "R9", "request ignored while held");
    cmdAck = 1; tick(); cmdAck = 0;
    check(32'(decValid), 0, "R9", "released after ack");

    // R3: window freeze
    curReq = "R3";
    wrReg(5, 'h107, 1);
    wrReg(0, mkRange(0, 'h1FFF, 1, 1), 0);
    rdExpect(0, mkRange('h010, 'h01F, 1, 1), "R3");
    wrReg(5, 'h007, 1);
    rdExpect(5, 'h107, "R3");
    issueExpect(0, 'h010000, 0, "R3");
    issueExpect(0, 'h000000, 1, "R3");
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
    rdExpect(5, 0, "R3");
    wrReg(0, mkRange(0, 'h1FFF, 1, 1), 0);
    rdExpect(0, mkRange(0, 'h1FFF, 1, 1), "R3");

    tick();
    finishRun();
  end
endmodule